// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A requester presents a virtual address; the walker reads the first-level descriptor from a 16 KB table whose base is given by an input. That descriptor either maps a 1 MB section directly, reports a fault, or points to a second-level table. A second-level table is either coarse (1 KB, 256 entries) or fine (4 KB, 1024 entries). The walker then reads one second-level descriptor, which maps a 64 KB large page, a 4 KB small page or a 1 KB tiny page.

The result carries the physical address, a size code, the 4-bit domain, the eight access-permission bits and the cacheable/bufferable pair, or a fault flag with the level that failed. The result is held until the requester acknowledges it. Memory is reached through a single read port: the walker raises a request with an address and waits for a valid strobe with the data. Permission checking, result caching and attribute interpretation are left to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: The first-level descriptor is read from address {tbl_base_hi, va[31:20], 2'b00}, where tbl_base_hi holds bits [31:14] of the 16 KB-aligned table base.
- R2: First-level type bits [1:0] decode as 00 fault, 01 coarse table, 10 section, 11 fine table; a section yields paddr = {desc[31:20], va[19:0]} and size code 3.
- R3: The second-level descriptor address is {desc[31:10], va[19:12], 2'b00} for a coarse table and {desc[31:12], va[19:10], 2'b00} for a fine table.
- R4: Second-level type 01 gives paddr {d[31:16], va[15:0]} with size code 2; type 10 gives {d[31:12], va[11:0]} with size code 1; type 11 in a fine table gives {d[31:10], va[9:0]} with size code 0.
- R5: rsp_domain is first-level bits [8:5] for every mapping; rsp_cb is {bit 3, bit 2} of the last descriptor read.
- R6: rsp_ap is section bits [11:10] repeated four times, large/small page bits [11:4], or tiny page bits [5:4] repeated four times.
- R7: First-level type 00 gives rsp_fault = 1 with rsp_fault_lvl = 0; second-level type 00, or type 11 in a coarse table, gives rsp_fault = 1 with rsp_fault_lvl = 1.
- R8: A section walk or first-level fault makes exactly one memory read; every other walk makes exactly two.
- R9: With memory answering one cycle after each request, rsp_valid rises 3 cycles after request acceptance for a one-read walk and 6 cycles after for a two-read walk.
- R10: A request is accepted only while req_ready is high; req_valid while a walk or response is pending starts nothing and does not change the pending result.
- R11: rsp_valid and all result fields stay unchanged until rsp_ack; the cycle after rsp_ack, rsp_valid is low and req_ready is high.
- R12: While rst_n is low, req_ready is 1, rsp_valid is 0 and mem_rd_req is 0, including when reset arrives in the middle of a walk.
- R13: mem_rd_addr stays constant while mem_rd_req is high and mem_rd_valid has not arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base_hi | input | 18 | Bits [31:14] of the first-level table base |
| req_valid | input | 1 | Translate request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Requester consumed the result |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl | output | 1 | Failing level: 0 first, 1 second |
| rsp_paddr | output | 32 | Physical address |
| rsp_size | output | 2 | 0 tiny, 1 small, 2 large, 3 section |
| rsp_domain | output | 4 | Domain number |
| rsp_cb | output | 2 | {cacheable, bufferable} |
| rsp_ap | output | 8 | Access-permission bits |

## Verification
The bench memory model answers each read one clock after it sees the request, so a one-read walk shows rsp_valid after the third rising edge that follows acceptance and a two-read walk after the sixth. The bench counts edges from acceptance and samples on falling edges. It checks the latency and the number of memory reads exactly, then reads the result fields in that cycle. Holding, ignoring and acknowledge behaviour are checked over the cycles that follow the first valid response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned VA_W       = 32;
  localparam int unsigned TBL_ALIGN  = 14;
  localparam int unsigned TBL_HI_W   = VA_W - TBL_ALIGN;
  localparam int unsigned SECT_SH    = 20;
  localparam int unsigned LARGE_SH   = 16;
  localparam int unsigned SMALL_SH   = 12;
  localparam int unsigned TINY_SH    = 10;
  localparam int unsigned L1_IDX_W   = VA_W - SECT_SH;
  localparam int unsigned C_BASE_LSB = 10;
  localparam int unsigned L1_HI_W    = VA_W - C_BASE_LSB;
  localparam int unsigned DOM_W      = 4;
  localparam int unsigned AP_W       = 8;
  localparam int unsigned AP_SUB_W   = 2;
  localparam int unsigned AP_REP     = AP_W / AP_SUB_W;
  localparam int unsigned CNT_W      = 2;

  localparam logic [1:0] SZ_TINY  = 2'd0;
  localparam logic [1:0] SZ_SMALL = 2'd1;
  localparam logic [1:0] SZ_LARGE = 2'd2;
  localparam logic [1:0] SZ_SECT  = 2'd3;

  typedef enum logic [2:0] {
    WS_IDLE, WS_L1_FETCH, WS_L1_DECODE, WS_L2_FETCH, WS_L2_DECODE, WS_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    L1K_FAULT  = 2'b00,
    L1K_COARSE = 2'b01,
    L1K_SECT   = 2'b10,
    L1K_FINE   = 2'b11
  } l1_kind_e;

  typedef struct packed {
    logic [L1_HI_W-1:0]  hi;
    logic [AP_SUB_W-1:0] ap;
    logic [DOM_W-1:0]    dom;
    logic [1:0]          cb;
    l1_kind_e            kind;
  } l1_fields_t;

  typedef struct packed {
    logic             fault;
    logic             lvl;
    logic [VA_W-1:0]  paddr;
    logic [1:0]       size;
    logic [DOM_W-1:0] dom;
    logic [1:0]       cb;
    logic [AP_W-1:0]  ap;
  } walk_res_t;

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  l1_fields_t      fld,
  input  logic [VA_W-1:0] va,
  output logic            walk_l2,
  output logic [VA_W-1:0] l2_addr,
  output walk_res_t       sect_res
);

  logic fine;

  assign fine    = (fld.kind == L1K_FINE);
  assign walk_l2 = (fld.kind == L1K_COARSE) || fine;

  always_comb begin
    if (fine) begin
      l2_addr = {fld.hi[L1_HI_W-1:SMALL_SH-C_BASE_LSB], va[SECT_SH-1:TINY_SH], 2'b00};
    end else begin
      l2_addr = {fld.hi, va[SECT_SH-1:SMALL_SH], 2'b00};
    end
  end

  always_comb begin
    sect_res.fault = (fld.kind == L1K_FAULT);
    sect_res.lvl   = 1'b0;
    sect_res.paddr = {fld.hi[L1_HI_W-1:SECT_SH-C_BASE_LSB], va[SECT_SH-1:0]};
    sect_res.size  = SZ_SECT;
    sect_res.dom   = fld.dom;
    sect_res.cb    = fld.cb;
    sect_res.ap    = {AP_REP{fld.ap}};
  end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  desc,
  input  logic [VA_W-1:0]  va,
  input  logic             fine,
  input  logic [DOM_W-1:0] dom,
  output walk_res_t        res
);

  always_comb begin
    res.fault = 1'b0;
    res.lvl   = 1'b1;
    res.paddr = '0;
    res.size  = SZ_TINY;
    res.dom   = dom;
    res.cb    = desc[3:2];
    res.ap    = desc[11:4];
    unique case (desc[1:0])
      2'b01: begin
        res.paddr = {desc[VA_W-1:LARGE_SH], va[LARGE_SH-1:0]};
        res.size  = SZ_LARGE;
      end
      2'b10: begin
        res.paddr = {desc[VA_W-1:SMALL_SH], va[SMALL_SH-1:0]};
        res.size  = SZ_SMALL;
      end
      2'b11: begin
        res.fault = !fine;
        res.paddr = {desc[VA_W-1:TINY_SH], va[TINY_SH-1:0]};
        res.size  = SZ_TINY;
        res.ap    = {AP_REP{desc[5:4]}};
      end
      default: res.fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TBL_HI_W-1:0] tbl_base_hi,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                mem_rd_req,
  output logic [VA_W-1:0]     mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [VA_W-1:0]     mem_rd_data,
  output logic                rsp_valid,
  input  logic                rsp_ack,
  output logic                rsp_fault,
  output logic                rsp_fault_lvl,
  output logic [VA_W-1:0]     rsp_paddr,
  output logic [1:0]          rsp_size,
  output logic [DOM_W-1:0]    rsp_domain,
  output logic [1:0]          rsp_cb,
  output logic [AP_W-1:0]     rsp_ap
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  walk_st_e        st_q, st_d;
  logic [VA_W-1:0] va_q;
  l1_fields_t      l1_q, l1_d;
  logic [VA_W-1:0] l2_q;
  walk_res_t       res_q, res_d;
  logic            va_en, l1_en, l2_en, res_en;

  logic            walk_l2;
  logic [VA_W-1:0] l2_addr;
  walk_res_t       sect_res, page_res;
  logic [VA_W-1:0] l1_addr;

  ptw_l1_decode u_l1 (
    .fld      (l1_q),
    .va       (va_q),
    .walk_l2  (walk_l2),
    .l2_addr  (l2_addr),
    .sect_res (sect_res)
  );

  ptw_l2_decode u_l2 (
    .desc (l2_q),
    .va   (va_q),
    .fine (l1_q.kind == L1K_FINE),
    .dom  (l1_q.dom),
    .res  (page_res)
  );

  assign l1_addr = {tbl_base_hi, va_q[VA_W-1:SECT_SH], 2'b00};

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:      if (req_valid)    st_d = WS_L1_FETCH;
      WS_L1_FETCH:  if (mem_rd_valid) st_d = WS_L1_DECODE;
      WS_L1_DECODE: st_d = walk_l2 ? WS_L2_FETCH : WS_DONE;
      WS_L2_FETCH:  if (mem_rd_valid) st_d = WS_L2_DECODE;
      WS_L2_DECODE: st_d = WS_DONE;
      WS_DONE:      if (rsp_ack)      st_d = WS_IDLE;
      default:      st_d = WS_IDLE;
    endcase
  end

  // clock enables and register inputs
  always_comb begin
    va_en  = (st_q == WS_IDLE) && req_valid;
    l1_en  = (st_q == WS_L1_FETCH) && mem_rd_valid;
    l2_en  = (st_q == WS_L2_FETCH) && mem_rd_valid;
    res_en = ((st_q == WS_L1_DECODE) && !walk_l2) || (st_q == WS_L2_DECODE);
    res_d  = (st_q == WS_L1_DECODE) ? sect_res : page_res;
    l1_d.hi   = mem_rd_data[VA_W-1:C_BASE_LSB];
    l1_d.ap   = mem_rd_data[11:10];
    l1_d.dom  = mem_rd_data[8:5];
    l1_d.cb   = mem_rd_data[3:2];
    l1_d.kind = l1_kind_e'(mem_rd_data[1:0]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WS_IDLE;
      va_q  <= '0;
      l1_q  <= '0;
      l2_q  <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      if (va_en)  va_q  <= req_vaddr;
      if (l1_en)  l1_q  <= l1_d;
      if (l2_en)  l2_q  <= mem_rd_data;
      if (res_en) res_q <= res_d;
    end
  end

  assign req_ready     = (st_q == WS_IDLE);
  assign mem_rd_req    = (st_q == WS_L1_FETCH) || (st_q == WS_L2_FETCH);
  assign mem_rd_addr   = (st_q == WS_L2_FETCH) ? l2_addr : l1_addr;
  assign rsp_valid     = (st_q == WS_DONE);
  assign rsp_fault     = res_q.fault;
  assign rsp_fault_lvl = res_q.lvl;
  assign rsp_paddr     = res_q.paddr;
  assign rsp_size      = res_q.size;
  assign rsp_domain    = res_q.dom;
  assign rsp_cb        = res_q.cb;
  assign rsp_ap        = res_q.ap;

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  logic [CNT_W-1:0] rd_seen_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen_q <= '0;
    end else if (req_valid && req_ready) begin
      rd_seen_q <= '0;
    end else if (mem_rd_req && mem_rd_valid && (rd_seen_q != '1)) begin
      rd_seen_q <= rd_seen_q + 1'b1;
    end
  end

  assert_rd_count_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rsp_valid) |->
      rd_seen_q == (((rsp_fault && !rsp_fault_lvl) || (!rsp_fault && rsp_size == SZ_SECT))
                    ? 2'd1 : 2'd2));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid && req_ready |=> mem_rd_req && !req_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                              && $stable(rsp_size) && $stable(rsp_ap));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid && rsp_ack |=> !rsp_valid && req_ready);

  assert_addr_stable_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_sect_offset_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rsp_valid) && !rsp_fault && rsp_size == SZ_SECT |->
      rsp_paddr[SECT_SH-1:0] == va_q[SECT_SH-1:0]);

  assert_tiny_offset_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rsp_valid) && !rsp_fault && rsp_size == SZ_TINY |->
      rsp_paddr[TINY_SH-1:0] == va_q[TINY_SH-1:0]);

  assert_one_read_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |-> !rsp_valid && !req_ready);

endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] tbl_base_hi;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        rsp_valid, rsp_ack, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_size, rsp_cb;
  logic [3:0]  rsp_domain;
  logic [7:0]  rsp_ap;

  int n_chk = 0;
  int n_err = 0;
  int n_reads = 0;

  always #10 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .tbl_base_hi(tbl_base_hi),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
    .rsp_domain(rsp_domain), .rsp_cb(rsp_cb), .rsp_ap(rsp_ap)
  );

  // memory model: answers one cycle after it sees a request
  logic [31:0] mem [logic [31:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else if (mem_rd_req && !mem_rd_valid) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
      n_reads      <= n_reads + 1;
    end else begin
      mem_rd_valid <= 1'b0;
    end
  end

  typedef struct packed {
    logic [17:0] base;
    logic [31:0] va;
    logic [31:0] pa;
    logic [1:0]  sz;
    logic        flt;
    logic        lvl;
    logic [3:0]  dom;
    logic [1:0]  cb;
    logic [7:0]  ap;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{18'd1, 32'h1234_5678, 32'hABC4_5678, 2'd3, 1'b0, 1'b0, 4'h5, 2'd2, 8'hFF, 4'd3},
    '{18'd1, 32'h2003_4ABC, 32'h7777_7ABC, 2'd1, 1'b0, 1'b0, 4'h9, 2'd3, 8'hE4, 4'd6},
    '{18'd1, 32'h2005_F123, 32'h8888_F123, 2'd2, 1'b0, 1'b0, 4'h9, 2'd1, 8'h1B, 4'd6},
    '{18'd1, 32'h300A_BCDE, 32'h1234_54DE, 2'd0, 1'b0, 1'b0, 4'hF, 2'd0, 8'hAA, 4'd6},
    '{18'd1, 32'h3000_1234, 32'h5555_5234, 2'd1, 1'b0, 1'b0, 4'hF, 2'd2, 8'h00, 4'd6},
    '{18'd1, 32'h4000_0000, 32'h0,         2'd0, 1'b1, 1'b0, 4'h0, 2'd0, 8'h00, 4'd3},
    '{18'd1, 32'h2000_0000, 32'h0,         2'd0, 1'b1, 1'b1, 4'h0, 2'd0, 8'h00, 4'd6},
    '{18'd1, 32'h2009_9000, 32'h0,         2'd0, 1'b1, 1'b1, 4'h0, 2'd0, 8'h00, 4'd6},
    '{18'd2, 32'h0010_0FFF, 32'hFFF0_0FFF, 2'd3, 1'b0, 1'b0, 4'h0, 2'd0, 8'h00, 4'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // launch one walk, optionally keep req_valid high with another address,
  // optionally hold the response for some cycles, then acknowledge
  task automatic walk(input vec_t v, input bit busy, input logic [31:0] other_va,
                      input int hold);
    int lat;
    int r0;
    logic [31:0] pa0;
    @(negedge clk);
    tbl_base_hi = v.base;
    req_vaddr   = v.va;
    req_valid   = 1'b1;
    r0          = n_reads;
    @(posedge clk);
    @(negedge clk);
    if (busy) req_vaddr = other_va;
    else      req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (busy) req_valid = 1'b0;
    chk("R9 latency", lat, {28'd0, v.lat});
    chk("R8 read count", n_reads - r0, (v.lat == 4'd3) ? 1 : 2);
    chk("R7 fault", {31'd0, rsp_fault}, {31'd0, v.flt});
    if (v.flt) begin
      chk("R7 fault level", {31'd0, rsp_fault_lvl}, {31'd0, v.lvl});
    end else begin
      chk("R1 R2 R3 R4 paddr", rsp_paddr, v.pa);
      chk("R2 R4 size", {30'd0, rsp_size}, {30'd0, v.sz});
      chk("R5 domain", {28'd0, rsp_domain}, {28'd0, v.dom});
      chk("R5 cb", {30'd0, rsp_cb}, {30'd0, v.cb});
      chk("R6 ap", {24'd0, rsp_ap}, {24'd0, v.ap});
    end
    pa0 = rsp_paddr;
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) begin
      chk("R11 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R11 held paddr", rsp_paddr, pa0);
      chk("R10 no read while pending", n_reads - r0, (v.lat == 4'd3) ? 1 : 2);
    end
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk("R11 released", {30'd0, rsp_valid, req_ready}, 32'd1);
    chk("R10 idle after ack", {31'd0, mem_rd_req}, 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    n_err++;
    $display("FAIL R9 watchdog expired: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ack = 1'b0;
    req_vaddr = '0; tbl_base_hi = 18'd1;
    mem[32'h0000_448C] = 32'hABC0_0CAA;
    mem[32'h0000_4800] = 32'h0001_0521;
    mem[32'h0001_04D0] = 32'h7777_7E4E;
    mem[32'h0001_057C] = 32'h8888_01B5;
    mem[32'h0001_0664] = 32'h1234_5423;
    mem[32'h0000_4C00] = 32'h0002_01E3;
    mem[32'h0002_0ABC] = 32'h1234_5423;
    mem[32'h0002_0010] = 32'h5555_500A;
    mem[32'h0000_8004] = 32'hFFF0_0002;

    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {29'd0, req_ready, rsp_valid, mem_rd_req}, 32'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 idle after reset", {29'd0, req_ready, rsp_valid, mem_rd_req}, 32'b100);

    for (int k = 0; k < NV; k++) walk(VECS[k], 1'b0, 32'h0, 0);

    // result held, extra req_valid ignored while busy
    walk(VECS[1], 1'b1, VECS[0].va, 4);
    walk(VECS[3], 1'b0, 32'h0, 3);

    // reset in the middle of a page walk
    @(negedge clk);
    tbl_base_hi = 18'd1; req_vaddr = VECS[2].va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 mid-walk reset", {29'd0, req_ready, rsp_valid, mem_rd_req}, 32'b100);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    walk(VECS[0], 1'b0, 32'h0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule